// File: doc/BRIEF.md
# Dual-Channel Segmented Converter Data Decoder

This block is the digital front end of a two-channel, 12-bit current-steering converter. Each channel takes an offset-binary data word. The word passes through a two-stage register pipeline. Its upper field is then expanded into a thermometer code of equal-weight segment enables. Its lower field leaves as binary-weighted switch controls. Every switch has a true control and a complementary control, so the current can be steered to one of two output rails. The in-phase (I) and quadrature (Q) channels are identical, share one clock and have the same latency.

A sleep input parks every switch control low and freezes both pipeline stages. When sleep is released, the words held in the pipeline come out first, and new data follows after two rising edges. The reset input is asserted asynchronously and released through a two-flop synchronizer. Reset clears both stages to code zero.

Top module: `dual_seg_dac_frontend`

## Requirements
- R1: While reset is active, every true control (segments and binary bits) is 0 and every complementary control is 1, on both channels.
- R2: Segment output bit k-1 (k = 1..31) is 1 exactly when bits [11:7] of the registered word, read as an unsigned number, are at least k. The segment vector is therefore always a thermometer code filled from bit 0 upward.
- R3: Binary output bits [6:0] equal bits [6:0] of the registered word, with no decoding.
- R4: While awake, each complementary control is the inverse of its true control.
- R5: A word on the input at rising edge N appears on the outputs after rising edge N+1. This is one clock period of latency, and it is the same for I and Q.
- R6: While awake, 128 × (true segments + complementary segments) + true binary value + complementary binary value always equals 4095. Code 0x000 puts all weight on the complementary rail. Code 0x800 turns on 16 true segments and no true binary bits. Code 0xFFF puts all weight on the true rail.
- R7: While sleep is 1, every true and every complementary control of both channels is 0.
- R8: While sleep is 1, the pipeline does not advance and input words are ignored. After release, the word held in the output stage shows first, then the word held in the first stage, then words applied after release.
- R9: The I and Q channels are independent: each channel's outputs depend only on its own input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| sleep | input | 1 | High: all controls low, pipeline frozen |
| i_word | input | 12 | I channel offset-binary word |
| q_word | input | 12 | Q channel offset-binary word |
| i_seg_p | output | 31 | I channel thermometer segment true controls |
| i_seg_n | output | 31 | I channel thermometer segment complementary controls |
| i_lsb_p | output | 7 | I channel binary switch true controls |
| i_lsb_n | output | 7 | I channel binary switch complementary controls |
| q_seg_p | output | 31 | Q channel thermometer segment true controls |
| q_seg_n | output | 31 | Q channel thermometer segment complementary controls |
| q_lsb_p | output | 7 | Q channel binary switch true controls |
| q_lsb_n | output | 7 | Q channel binary switch complementary controls |

## Verification
The hardest case to reach from the ports is a sleep period entered with two different words in flight. The outputs are forced to zero during sleep, so the frozen pipeline can only be seen after release. The stimulus first streams two distinct words. It then raises sleep and changes the inputs to a word that must never show. Finally it releases sleep and checks, one edge at a time, that both held words come out in order before the newly applied word.

// File: rtl/dsdf_pkg.sv
package dsdf_pkg;
  localparam int unsigned DEF_DATA_W   = 12;
  localparam int unsigned DEF_SEG_BITS = 5;
  localparam int unsigned CH_COUNT     = 2;

  typedef enum logic [0:0] {
    CH_I = 1'b0,
    CH_Q = 1'b1
  } chan_e;
endpackage

// File: rtl/dsdf_rst_sync.sv
module dsdf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_core_n = hold_q;
endmodule

// File: rtl/dsdf_word_pipe.sv
module dsdf_word_pipe #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] cap_q, cap_d;
  logic [W-1:0] drv_q, drv_d;

  // next state: both stages move together when enabled, else hold
  always_comb begin
    cap_d = cap_q;
    drv_d = drv_q;
    if (adv_en) begin
      cap_d = din;
      drv_d = cap_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      drv_q <= '0;
    end else begin
      cap_q <= cap_d;
      drv_q <= drv_d;
    end
  end

  assign dout = drv_q;
endmodule

// File: rtl/dsdf_thermo_dec.sv
module dsdf_thermo_dec #(
  parameter int unsigned IN_W = 5,
  localparam int unsigned OUT_N = (1 << IN_W) - 1
) (
  input  logic [IN_W-1:0]  code,
  output logic [OUT_N-1:0] therm
);
  for (genvar k = 1; k <= OUT_N; k++) begin : g_seg
    assign therm[k-1] = (code >= IN_W'(k));
  end
endmodule

// File: rtl/dsdf_switch_drv.sv
module dsdf_switch_drv #(
  parameter int unsigned SEG_N = 31,
  parameter int unsigned LSB_W = 7
) (
  input  logic             sleep,
  input  logic [SEG_N-1:0] seg,
  input  logic [LSB_W-1:0] lsb,
  output logic [SEG_N-1:0] seg_p,
  output logic [SEG_N-1:0] seg_n,
  output logic [LSB_W-1:0] lsb_p,
  output logic [LSB_W-1:0] lsb_n
);
  logic             drive_en;
  logic [SEG_N-1:0] seg_mask;
  logic [LSB_W-1:0] lsb_mask;

  always_comb begin
    drive_en = ~sleep;
    seg_mask = {SEG_N{drive_en}};
    lsb_mask = {LSB_W{drive_en}};
    seg_p    = seg  & seg_mask;
    seg_n    = ~seg & seg_mask;
    lsb_p    = lsb  & lsb_mask;
    lsb_n    = ~lsb & lsb_mask;
  end
endmodule

// File: rtl/dsdf_channel.sv
module dsdf_channel #(
  parameter int unsigned DATA_W   = 12,
  parameter int unsigned SEG_BITS = 5,
  localparam int unsigned LSB_W = DATA_W - SEG_BITS,
  localparam int unsigned SEG_N = (1 << SEG_BITS) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic [DATA_W-1:0] word,
  output logic [SEG_N-1:0]  seg_p,
  output logic [SEG_N-1:0]  seg_n,
  output logic [LSB_W-1:0]  lsb_p,
  output logic [LSB_W-1:0]  lsb_n
);
  logic              adv_en;
  logic [DATA_W-1:0] held_word;
  logic [SEG_N-1:0]  therm;

  assign adv_en = ~sleep;

  dsdf_word_pipe #(.W(DATA_W)) u_pipe (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_en (adv_en),
    .din    (word),
    .dout   (held_word)
  );

  dsdf_thermo_dec #(.IN_W(SEG_BITS)) u_dec (
    .code  (held_word[DATA_W-1:LSB_W]),
    .therm (therm)
  );

  dsdf_switch_drv #(.SEG_N(SEG_N), .LSB_W(LSB_W)) u_drv (
    .sleep (sleep),
    .seg   (therm),
    .lsb   (held_word[LSB_W-1:0]),
    .seg_p (seg_p),
    .seg_n (seg_n),
    .lsb_p (lsb_p),
    .lsb_n (lsb_n)
  );
endmodule

// File: rtl/dual_seg_dac_frontend.sv
module dual_seg_dac_frontend
  import dsdf_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned SEG_BITS = DEF_SEG_BITS,
  localparam int unsigned LSB_W = DATA_W - SEG_BITS,
  localparam int unsigned SEG_N = (1 << SEG_BITS) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic [DATA_W-1:0] i_word,
  input  logic [DATA_W-1:0] q_word,
  output logic [SEG_N-1:0]  i_seg_p,
  output logic [SEG_N-1:0]  i_seg_n,
  output logic [LSB_W-1:0]  i_lsb_p,
  output logic [LSB_W-1:0]  i_lsb_n,
  output logic [SEG_N-1:0]  q_seg_p,
  output logic [SEG_N-1:0]  q_seg_n,
  output logic [LSB_W-1:0]  q_lsb_p,
  output logic [LSB_W-1:0]  q_lsb_n
);
  logic rst_core_n;

  logic [DATA_W-1:0] ch_word  [CH_COUNT];
  logic [SEG_N-1:0]  ch_seg_p [CH_COUNT];
  logic [SEG_N-1:0]  ch_seg_n [CH_COUNT];
  logic [LSB_W-1:0]  ch_lsb_p [CH_COUNT];
  logic [LSB_W-1:0]  ch_lsb_n [CH_COUNT];

  dsdf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  assign ch_word[CH_I] = i_word;
  assign ch_word[CH_Q] = q_word;

  for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
    dsdf_channel #(.DATA_W(DATA_W), .SEG_BITS(SEG_BITS)) u_ch (
      .clk   (clk),
      .rst_n (rst_core_n),
      .sleep (sleep),
      .word  (ch_word[c]),
      .seg_p (ch_seg_p[c]),
      .seg_n (ch_seg_n[c]),
      .lsb_p (ch_lsb_p[c]),
      .lsb_n (ch_lsb_n[c])
    );
  end

  assign i_seg_p = ch_seg_p[CH_I];
  assign i_seg_n = ch_seg_n[CH_I];
  assign i_lsb_p = ch_lsb_p[CH_I];
  assign i_lsb_n = ch_lsb_n[CH_I];
  assign q_seg_p = ch_seg_p[CH_Q];
  assign q_seg_n = ch_seg_n[CH_Q];
  assign q_lsb_p = ch_lsb_p[CH_Q];
  assign q_lsb_n = ch_lsb_n[CH_Q];
endmodule

// File: rtl/dsdf_checker.sv
module dsdf_checker #(
  parameter int unsigned DATA_W   = 12,
  parameter int unsigned SEG_BITS = 5,
  localparam int unsigned LSB_W = DATA_W - SEG_BITS,
  localparam int unsigned SEG_N = (1 << SEG_BITS) - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic [DATA_W-1:0] i_word,
  input logic [DATA_W-1:0] q_word,
  input logic [SEG_N-1:0]  i_seg_p,
  input logic [SEG_N-1:0]  i_seg_n,
  input logic [LSB_W-1:0]  i_lsb_p,
  input logic [LSB_W-1:0]  i_lsb_n,
  input logic [SEG_N-1:0]  q_seg_p,
  input logic [SEG_N-1:0]  q_seg_n,
  input logic [LSB_W-1:0]  q_lsb_p,
  input logic [LSB_W-1:0]  q_lsb_n
);
  localparam int FULL = (1 << DATA_W) - 1;
  localparam int STEP = 1 << LSB_W;

  logic [1:0]          warm;
  logic [SEG_BITS-1:0] i_cnt, q_cnt;
  int                  i_sum, q_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  always_comb begin
    i_cnt = SEG_BITS'($countones(i_seg_p));
    q_cnt = SEG_BITS'($countones(q_seg_p));
    i_sum = ($countones(i_seg_p) + $countones(i_seg_n)) * STEP + int'(i_lsb_p) + int'(i_lsb_n);
    q_sum = ($countones(q_seg_p) + $countones(q_seg_n)) * STEP + int'(q_lsb_p) + int'(q_lsb_n);
  end

  // R1: right after release the cleared pipeline shows code zero
  p_reset_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd0 && !sleep) |-> (i_seg_p == '0 && i_seg_n == '1 && i_lsb_p == '0 && i_lsb_n == '1
                                  && q_seg_p == '0 && q_seg_n == '1 && q_lsb_p == '0 && q_lsb_n == '1));

  // R2: segments always form a thermometer filled from bit 0
  p_thermo_shape_i_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((i_seg_p >> 1) & ~i_seg_p) == '0);
  p_thermo_shape_q_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((q_seg_p >> 1) & ~q_seg_p) == '0);

  // R4: complementary controls while awake
  p_compl_i_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |-> (i_seg_n == ~i_seg_p && i_lsb_n == ~i_lsb_p));
  p_compl_q_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |-> (q_seg_n == ~q_seg_p && q_lsb_n == ~q_lsb_p));

  // R5: word captured two edges ago is reconstructed from the outputs
  p_latency_i_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && !sleep && !$past(sleep) && !$past(sleep, 2)) |-> ({i_cnt, i_lsb_p} == $past(i_word, 2)));
  p_latency_q_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && !sleep && !$past(sleep) && !$past(sleep, 2)) |-> ({q_cnt, q_lsb_p} == $past(q_word, 2)));

  // R6: total weight on both rails is full scale minus one step
  p_weight_i_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |-> (i_sum == FULL));
  p_weight_q_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |-> (q_sum == FULL));

  // R7: sleep parks every control low
  p_sleep_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (i_seg_p == '0 && i_seg_n == '0 && i_lsb_p == '0 && i_lsb_n == '0
               && q_seg_p == '0 && q_seg_n == '0 && q_lsb_p == '0 && q_lsb_n == '0));
endmodule

bind dual_seg_dac_frontend dsdf_checker #(.DATA_W(DATA_W), .SEG_BITS(SEG_BITS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .sleep   (sleep),
  .i_word  (i_word),
  .q_word  (q_word),
  .i_seg_p (i_seg_p),
  .i_seg_n (i_seg_n),
  .i_lsb_p (i_lsb_p),
  .i_lsb_n (i_lsb_n),
  .q_seg_p (q_seg_p),
  .q_seg_n (q_seg_n),
  .q_lsb_p (q_lsb_p),
  .q_lsb_n (q_lsb_n)
);

// File: tb/sim_dual_seg_dac_frontend.sv
module sim_dual_seg_dac_frontend;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sleep;
  logic [11:0] i_word, q_word;
  logic [30:0] i_seg_p, i_seg_n, q_seg_p, q_seg_n;
  logic [6:0]  i_lsb_p, i_lsb_n, q_lsb_p, q_lsb_n;

  int checks   = 0;
  int failures = 0;
  int cyc      = 0;
  bit done     = 0;

  int          sb_due[$];
  logic [11:0] sb_iw[$];
  logic [11:0] sb_qw[$];

  dual_seg_dac_frontend u0 (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .i_word(i_word), .q_word(q_word),
    .i_seg_p(i_seg_p), .i_seg_n(i_seg_n), .i_lsb_p(i_lsb_p), .i_lsb_n(i_lsb_n),
    .q_seg_p(q_seg_p), .q_seg_n(q_seg_n), .q_lsb_p(q_lsb_p), .q_lsb_n(q_lsb_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [30:0] exp_seg(logic [11:0] w);
    logic [30:0] r;
    for (int k = 1; k <= 31; k++) r[k-1] = (int'(w[11:7]) >= k);
    return r;
  endfunction

  task automatic check_vec(string tag, logic [75:0] act, logic [75:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare one channel's controls against the word it should show
  task automatic check_chan(string tag, logic [11:0] w,
                            logic [30:0] sp, logic [30:0] sn, logic [6:0] lp, logic [6:0] ln);
    int sum;
    check_vec(tag, {sp, sn, lp, ln}, {exp_seg(w), ~exp_seg(w), w[6:0], ~w[6:0]});
    sum = ($countones(sp) + $countones(sn)) * 128 + int'(lp) + int'(ln);
    check_vec({tag, " R6 weight"}, 76'(sum), 76'(4095));
  endtask

  task automatic check_idle(string tag);
    check_vec({tag, " I"}, {i_seg_p, i_seg_n, i_lsb_p, i_lsb_n}, '0);
    check_vec({tag, " Q"}, {q_seg_p, q_seg_n, q_lsb_p, q_lsb_n}, '0);
  endtask

  // driver: apply a word pair and queue its expected appearance
  task automatic drive(logic [11:0] iw, logic [11:0] qw);
    @(negedge clk);
    i_word = iw;
    q_word = qw;
    sb_due.push_back(cyc + 2);
    sb_iw.push_back(iw);
    sb_qw.push_back(qw);
  endtask

  // monitor: pop and compare when a queued word is due (R2 R3 R4 R5 R9)
  always @(negedge clk) begin
    if (sb_due.size() > 0 && sb_due[0] == cyc) begin
      logic [11:0] ew_i, ew_q;
      void'(sb_due.pop_front());
      ew_i = sb_iw.pop_front();
      ew_q = sb_qw.pop_front();
      check_chan("R2/R3/R4/R5 I", ew_i, i_seg_p, i_seg_n, i_lsb_p, i_lsb_n);
      check_chan("R9/R5 Q", ew_q, q_seg_p, q_seg_n, q_lsb_p, q_lsb_n);
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n  = 1'b0;
    sleep  = 1'b0;
    i_word = 12'hABC;
    q_word = 12'h5A5;
    repeat (4) @(negedge clk);
    // R1: reset state on both rails
    check_chan("R1 reset I", 12'h000, i_seg_p, i_seg_n, i_lsb_p, i_lsb_n);
    check_chan("R1 reset Q", 12'h000, q_seg_p, q_seg_n, q_lsb_p, q_lsb_n);
    i_word = 12'h000;
    q_word = 12'h000;
    rst_n  = 1'b1;
    repeat (5) @(negedge clk);

    // R6 endpoints and R9 opposite words on the two channels
    drive(12'h000, 12'hFFF);
    drive(12'h800, 12'h7FF);
    drive(12'hFFF, 12'h000);
    drive(12'h07F, 12'h080);
    drive(12'hF80, 12'h001);
    drive(12'h7FF, 12'h800);
    for (int k = 0; k < 40; k++)
      drive(12'((k * 1443 + 17) & 12'hFFF), 12'((k * 2671 + 901) & 12'hFFF));
    repeat (4) @(negedge clk);

    // R7 and R8: freeze with two different words in flight
    drive(12'h123, 12'hE01);
    drive(12'h9A5, 12'h3C7);
    @(negedge clk);
    // the monitor checked 0x123 at this edge; now sleep
    sb_due.delete(); sb_iw.delete(); sb_qw.delete();
    sleep  = 1'b1;
    i_word = 12'h555;
    q_word = 12'hAAA;
    #1 check_idle("R7 sleep entry");
    @(negedge clk);
    check_idle("R7 sleep held");
    @(negedge clk);
    check_idle("R7 sleep held 2");
    sleep  = 1'b0;
    i_word = 12'h3F0;
    q_word = 12'h0C3;
    #1;
    check_chan("R8 release stage2 I", 12'h123, i_seg_p, i_seg_n, i_lsb_p, i_lsb_n);
    check_chan("R8 release stage2 Q", 12'hE01, q_seg_p, q_seg_n, q_lsb_p, q_lsb_n);
    @(negedge clk);
    check_chan("R8 release stage1 I", 12'h9A5, i_seg_p, i_seg_n, i_lsb_p, i_lsb_n);
    check_chan("R8 release stage1 Q", 12'h3C7, q_seg_p, q_seg_n, q_lsb_p, q_lsb_n);
    @(negedge clk);
    check_chan("R8 first new word I", 12'h3F0, i_seg_p, i_seg_n, i_lsb_p, i_lsb_n);
    check_chan("R8 first new word Q", 12'h0C3, q_seg_p, q_seg_n, q_lsb_p, q_lsb_n);

    // back to streaming after sleep
    drive(12'h800, 12'h800);
    drive(12'h0FF, 12'hF00);
    drive(12'hFFF, 12'hFFF);
    repeat (4) @(negedge clk);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule